// File: doc/BRIEF.md
# Dual-Lane Instruction Issue Steering

This block sits between instruction fetch and a two-lane execution core. It receives one aligned 32-bit fetch word per cycle. The word holds either two 16-bit short instructions or one 32-bit long instruction. The slot at bits 15:0 is the lower address and comes first in program order. A predecode stage supplies the class of each slot, a long-instruction flag, and the register fields the block needs to spot a read-after-write between the two slots.

Each cycle the block routes the slots to the two lanes:

- The resource lane accepts I/O/resource instructions and arithmetic.
- The memory lane accepts memory instructions, branches and arithmetic.

If both slots can go out together, the block issues them together. If they cannot, it issues the first slot and raises a stall to fetch. The fetch word must then be held for one more cycle, during which the second slot goes out alone. A mode input forces one instruction per cycle.

Top module: `dual_lane_steer`

## Requirements
- R1: Class codes are 00 arithmetic, 01 resource, 10 memory, 11 branch. The resource lane only ever carries arithmetic or resource instructions. The memory lane never carries a resource instruction.
- R2: A short instruction issued alone goes to the resource lane if it is a resource instruction, and to the memory lane otherwise (arithmetic included). A short instruction appears on its lane zero-extended to 32 bits.
- R3: A long instruction drives both lanes in the same cycle. Each lane carries the full 32-bit word and the class of the low slot. There is no stall.
- R4: When two independent short instructions are both arithmetic, the low slot goes to the memory lane and the high slot to the resource lane, in one cycle.
- R5: When both short slots can only use the same single lane, the low slot issues alone and the stall is raised. On the next cycle the high slot issues alone and the stall is low.
- R6: When the low slot writes a register (write-enable high) whose number equals either source register of the high slot, the pair is split over two cycles in program order, as in R5.
- R7: A branch in the low slot issues on the memory lane. The high slot is discarded and no stall is raised.
- R8: With single-issue mode high, at most one short instruction issues per cycle, with the split behaviour of R5.
- R9: With fetch-valid low, neither lane is valid and no stall is raised. Reset clears a pending second half, so the next word starts from its low slot.
- R10: Compatible pairs that need no split issue in one cycle on opposite lanes: a resource instruction takes the resource lane and the other slot takes the memory lane.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | Fetch word present |
| fetchWord | input | 32 | Aligned fetch word; bits 15:0 are the low slot |
| loClass | input | 2 | Class of the low slot |
| hiClass | input | 2 | Class of the high slot |
| isLong | input | 1 | Word is one 32-bit instruction |
| loWrEn | input | 1 | Low slot writes a register |
| loDst | input | 4 | Register written by the low slot |
| hiSrcA | input | 4 | First register read by the high slot |
| hiSrcB | input | 4 | Second register read by the high slot |
| singleIssue | input | 1 | Force one instruction per cycle |
| resValid | output | 1 | Resource lane carries an instruction |
| resInstr | output | 32 | Resource lane instruction |
| resClass | output | 2 | Resource lane class |
| memValid | output | 1 | Memory lane carries an instruction |
| memInstr | output | 32 | Memory lane instruction |
| memClass | output | 2 | Memory lane class |
| fetchStall | output | 1 | Hold the current fetch word one more cycle |

## Verification
The bench tests every ordered pairing of classes that matters. A design that mixed up which arithmetic slot takes which lane would swap the two lane words. A design that missed a same-lane clash would put a memory or branch instruction on the resource lane. Register dependencies are tested through both source fields, and also with write-enable low, where a false split would show up as an unneeded stall. Further tests cover a branch in the low slot (a broken design would leak the high slot or stall), single-issue mode on long and short words, and a reset taken between the two halves of a split (a broken design would resume on the high slot).

// File: rtl/steer_pkg.sv
package steer_pkg;
  typedef enum logic [1:0] {
    CLS_ALU = 2'b00,
    CLS_RES = 2'b01,
    CLS_MEM = 2'b10,
    CLS_BR  = 2'b11
  } instrClassT;

  // Which part of the fetch word a lane receives
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_LO   = 2'b01,
    SRC_HI   = 2'b10,
    SRC_FULL = 2'b11
  } laneSrcT;

  typedef struct packed {
    laneSrcT resSrc;
    laneSrcT memSrc;
  } laneStrobeT;
endpackage

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
#(
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [1:0]        loClass,
  input  logic [1:0]        hiClass,
  input  logic              isLong,
  input  logic              loWrEn,
  input  logic [REG_AW-1:0] loDst,
  input  logic [REG_AW-1:0] hiSrcA,
  input  logic [REG_AW-1:0] hiSrcB,
  input  logic              singleIssue,
  output laneStrobeT        strobe,
  output logic              fetchStall
);
  logic       secondHalf, nextHalf;
  instrClassT c0, c1;
  logic       rawHazard, laneClash, mustSplit;

  assign c0 = instrClassT'(loClass);
  assign c1 = instrClassT'(hiClass);

  function automatic logic memOnly(input instrClassT c);
    return (c == CLS_MEM) || (c == CLS_BR);
  endfunction

  function automatic laneStrobeT alone(input instrClassT c, input laneSrcT s);
    laneStrobeT r;
    r.resSrc = (c == CLS_RES) ? s : SRC_NONE;
    r.memSrc = (c == CLS_RES) ? SRC_NONE : s;
    return r;
  endfunction

  assign rawHazard = loWrEn && ((loDst == hiSrcA) || (loDst == hiSrcB));
  assign laneClash = ((c0 == CLS_RES) && (c1 == CLS_RES)) || (memOnly(c0) && memOnly(c1));
  assign mustSplit = singleIssue || rawHazard || laneClash;

  always_comb begin
    strobe     = '{resSrc: SRC_NONE, memSrc: SRC_NONE};
    fetchStall = 1'b0;
    nextHalf   = secondHalf;
    if (fetchValid) begin
      if (secondHalf) begin
        strobe   = alone(c1, SRC_HI);
        nextHalf = 1'b0;
      end else if (isLong) begin
        strobe = '{resSrc: SRC_FULL, memSrc: SRC_FULL};
      end else if (c0 == CLS_BR) begin
        strobe.memSrc = SRC_LO;
      end else if (mustSplit) begin
        strobe     = alone(c0, SRC_LO);
        fetchStall = 1'b1;
        nextHalf   = 1'b1;
      end else if (c0 == CLS_RES || (c0 == CLS_ALU && c1 != CLS_ALU && c1 != CLS_RES)) begin
        strobe = '{resSrc: SRC_LO, memSrc: SRC_HI};
      end else begin
        strobe = '{resSrc: SRC_HI, memSrc: SRC_LO};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) secondHalf <= 1'b0;
    else       secondHalf <= nextHalf;
  end

  // R3: a long word never needs a second cycle
  assert_long_nostall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && isLong && !secondHalf) |-> !fetchStall);
  // R5: a stall is always followed by a stall-free cycle
  assert_stall_once_R5: assert property (@(posedge clk) disable iff (!rstN)
    fetchStall |=> !fetchStall);
  // R8: single-issue mode never fills both lanes with shorts
  assert_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    (singleIssue && !isLong) |-> !(strobe.resSrc != SRC_NONE && strobe.memSrc != SRC_NONE));
  // R9: no fetch word, no issue and no stall
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |-> (strobe.resSrc == SRC_NONE && strobe.memSrc == SRC_NONE && !fetchStall));
endmodule

// File: rtl/steer_dp.sv
module steer_dp
  import steer_pkg::*;
#(
  parameter int SHORT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2*SHORT_W-1:0] fetchWord,
  input  logic [1:0]           loClass,
  input  logic [1:0]           hiClass,
  input  laneStrobeT           strobe,
  output logic                 resValid,
  output logic [2*SHORT_W-1:0] resInstr,
  output logic [1:0]           resClass,
  output logic                 memValid,
  output logic [2*SHORT_W-1:0] memInstr,
  output logic [1:0]           memClass
);
  localparam int WORD_W = 2 * SHORT_W;

  logic [SHORT_W-1:0] loHalf, hiHalf;
  assign loHalf = fetchWord[SHORT_W-1:0];
  assign hiHalf = fetchWord[WORD_W-1:SHORT_W];

  function automatic logic [WORD_W-1:0] pickWord(input laneSrcT s,
      input logic [SHORT_W-1:0] lo, input logic [SHORT_W-1:0] hi);
    case (s)
      SRC_LO:   return {{SHORT_W{1'b0}}, lo};
      SRC_HI:   return {{SHORT_W{1'b0}}, hi};
      SRC_FULL: return {hi, lo};
      default:  return '0;
    endcase
  endfunction

  function automatic logic [1:0] pickClass(input laneSrcT s,
      input logic [1:0] lo, input logic [1:0] hi);
    return (s == SRC_HI) ? hi : ((s == SRC_NONE) ? 2'b00 : lo);
  endfunction

  assign resValid = (strobe.resSrc != SRC_NONE);
  assign memValid = (strobe.memSrc != SRC_NONE);
  assign resInstr = pickWord(strobe.resSrc, loHalf, hiHalf);
  assign memInstr = pickWord(strobe.memSrc, loHalf, hiHalf);
  assign resClass = pickClass(strobe.resSrc, loClass, hiClass);
  assign memClass = pickClass(strobe.memSrc, loClass, hiClass);

  // R1: lane eligibility by class on the short path
  assert_res_class_R1: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && strobe.resSrc != SRC_FULL) |-> (resClass == CLS_ALU || resClass == CLS_RES));
  assert_mem_class_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && strobe.memSrc != SRC_FULL) |-> (memClass != CLS_RES));
  // R3: a long word occupies both lanes together
  assert_long_both_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.resSrc == SRC_FULL) |-> (memValid && memInstr == resInstr));
endmodule

// File: rtl/dual_lane_steer.sv
module dual_lane_steer
  import steer_pkg::*;
#(
  parameter int SHORT_W = 16,
  parameter int REG_AW  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fetchValid,
  input  logic [2*SHORT_W-1:0] fetchWord,
  input  logic [1:0]           loClass,
  input  logic [1:0]           hiClass,
  input  logic                 isLong,
  input  logic                 loWrEn,
  input  logic [REG_AW-1:0]    loDst,
  input  logic [REG_AW-1:0]    hiSrcA,
  input  logic [REG_AW-1:0]    hiSrcB,
  input  logic                 singleIssue,
  output logic                 resValid,
  output logic [2*SHORT_W-1:0] resInstr,
  output logic [1:0]           resClass,
  output logic                 memValid,
  output logic [2*SHORT_W-1:0] memInstr,
  output logic [1:0]           memClass,
  output logic                 fetchStall
);
  laneStrobeT strobe;

  steer_ctrl #(.REG_AW(REG_AW)) uCtrl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid),
    .loClass(loClass), .hiClass(hiClass), .isLong(isLong),
    .loWrEn(loWrEn), .loDst(loDst), .hiSrcA(hiSrcA), .hiSrcB(hiSrcB),
    .singleIssue(singleIssue), .strobe(strobe), .fetchStall(fetchStall)
  );

  steer_dp #(.SHORT_W(SHORT_W)) uDp (
    .clk(clk), .rstN(rstN), .fetchWord(fetchWord),
    .loClass(loClass), .hiClass(hiClass), .strobe(strobe),
    .resValid(resValid), .resInstr(resInstr), .resClass(resClass),
    .memValid(memValid), .memInstr(memInstr), .memClass(memClass)
  );
endmodule

// File: tb/tb_dual_lane_steer.sv
module tb_dual_lane_steer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  // lane source codes: 0 none, 1 low slot, 2 high slot, 3 whole word
  typedef struct packed {
    logic [1:0] c0, c1;
    logic       lng, sgl, wr;
    logic [3:0] dst, sa, sb;
    logic [1:0] r1, m1;
    logic       st;
    logic [1:0] r2, m2;
  } vecT;

  localparam vecT VECS [NVEC] = '{
    '{2'd0,2'd0,1'b0,1'b0,1'b1,4'd0,4'd1,4'd2, 2'd2,2'd1,1'b0, 2'd0,2'd0}, // R4 A,A
    '{2'd2,2'd2,1'b0,1'b0,1'b1,4'd0,4'd1,4'd2, 2'd0,2'd1,1'b1, 2'd0,2'd2}, // R5 M,M
    '{2'd1,2'd1,1'b0,1'b0,1'b1,4'd0,4'd1,4'd2, 2'd1,2'd0,1'b1, 2'd2,2'd0}, // R5 R,R
    '{2'd2,2'd0,1'b0,1'b0,1'b1,4'd0,4'd1,4'd2, 2'd2,2'd1,1'b0, 2'd0,2'd0}, // R10 M,A
    '{2'd0,2'd2,1'b0,1'b0,1'b1,4'd0,4'd1,4'd2, 2'd1,2'd2,1'b0, 2'd0,2'd0}, // R10 A,M
    '{2'd1,2'd0,1'b0,1'b0,1'b1,4'd0,4'd1,4'd2, 2'd1,2'd2,1'b0, 2'd0,2'd0}, // R10 R,A
    '{2'd0,2'd1,1'b0,1'b0,1'b1,4'd0,4'd1,4'd2, 2'd2,2'd1,1'b0, 2'd0,2'd0}, // R10 A,R
    '{2'd1,2'd2,1'b0,1'b0,1'b1,4'd0,4'd1,4'd2, 2'd1,2'd2,1'b0, 2'd0,2'd0}, // R10 R,M
    '{2'd3,2'd0,1'b0,1'b0,1'b1,4'd0,4'd1,4'd2, 2'd0,2'd1,1'b0, 2'd0,2'd0}, // R7 B,A
    '{2'd3,2'd2,1'b0,1'b0,1'b1,4'd0,4'd1,4'd2, 2'd0,2'd1,1'b0, 2'd0,2'd0}, // R7 B,M
    '{2'd0,2'd3,1'b0,1'b0,1'b1,4'd0,4'd1,4'd2, 2'd1,2'd2,1'b0, 2'd0,2'd0}, // R10 A,B
    '{2'd2,2'd3,1'b0,1'b0,1'b1,4'd0,4'd1,4'd2, 2'd0,2'd1,1'b1, 2'd0,2'd2}, // R5 M,B
    '{2'd1,2'd0,1'b1,1'b0,1'b1,4'd0,4'd1,4'd2, 2'd3,2'd3,1'b0, 2'd0,2'd0}, // R3 long
    '{2'd0,2'd0,1'b0,1'b0,1'b1,4'd3,4'd3,4'd2, 2'd0,2'd1,1'b1, 2'd0,2'd2}, // R6 srcA
    '{2'd0,2'd1,1'b0,1'b0,1'b1,4'd7,4'd1,4'd7, 2'd0,2'd1,1'b1, 2'd2,2'd0}, // R6 srcB
    '{2'd0,2'd0,1'b0,1'b0,1'b0,4'd3,4'd3,4'd3, 2'd2,2'd1,1'b0, 2'd0,2'd0}, // R6 no write
    '{2'd1,2'd2,1'b0,1'b1,1'b1,4'd0,4'd1,4'd2, 2'd1,2'd0,1'b1, 2'd0,2'd2}, // R8 single
    '{2'd2,2'd0,1'b1,1'b1,1'b1,4'd0,4'd1,4'd2, 2'd3,2'd3,1'b0, 2'd0,2'd0}  // R8 single long
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic fetchValid = 1'b0, isLong = 1'b0, loWrEn = 1'b0, singleIssue = 1'b0;
  logic [31:0] fetchWord = '0;
  logic [1:0]  loClass = '0, hiClass = '0;
  logic [3:0]  loDst = '0, hiSrcA = '0, hiSrcB = '0;
  logic resValid, memValid, fetchStall;
  logic [31:0] resInstr, memInstr;
  logic [1:0]  resClass, memClass;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_lane_steer dut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchWord(fetchWord),
    .loClass(loClass), .hiClass(hiClass), .isLong(isLong), .loWrEn(loWrEn),
    .loDst(loDst), .hiSrcA(hiSrcA), .hiSrcB(hiSrcB), .singleIssue(singleIssue),
    .resValid(resValid), .resInstr(resInstr), .resClass(resClass),
    .memValid(memValid), .memInstr(memInstr), .memClass(memClass),
    .fetchStall(fetchStall)
  );

  function automatic logic [31:0] expWord(input logic [1:0] s, input logic [31:0] w);
    case (s)
      2'd1: return {16'h0, w[15:0]};
      2'd2: return {16'h0, w[31:16]};
      2'd3: return w;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [1:0] expCls(input logic [1:0] s, input logic [1:0] a, input logic [1:0] b);
    return (s == 2'd2) ? b : ((s == 2'd0) ? 2'd0 : a);
  endfunction

  task automatic checkLanes(input string req, input logic [1:0] rs, input logic [1:0] ms, input logic st);
    logic [31:0] eR, eM;
    logic [1:0]  cR, cM;
    logic ok;
    eR = expWord(rs, fetchWord); eM = expWord(ms, fetchWord);
    cR = expCls(rs, loClass, hiClass); cM = expCls(ms, loClass, hiClass);
    ok = (resValid == (rs != 0)) && (memValid == (ms != 0)) && (fetchStall == st)
      && (rs == 0 || (resInstr == eR && resClass == cR))
      && (ms == 0 || (memInstr == eM && memClass == cM));
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: res v=%0b %h c=%0d mem v=%0b %h c=%0d stall=%0b ; expected res v=%0b %h c=%0d mem v=%0b %h c=%0d stall=%0b",
        req, resValid, resInstr, resClass, memValid, memInstr, memClass, fetchStall,
        rs != 0, eR, cR, ms != 0, eM, cM, st);
    end
  endtask

  task automatic loadVec(input vecT v, input logic [31:0] w);
    fetchValid = 1'b1; fetchWord = w; loClass = v.c0; hiClass = v.c1;
    isLong = v.lng; singleIssue = v.sgl; loWrEn = v.wr;
    loDst = v.dst; hiSrcA = v.sa; hiSrcB = v.sb;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not complete, actual hung, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkLanes("R9 reset idle", 2'd0, 2'd0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkLanes("R9 no fetch", 2'd0, 2'd0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      loadVec(VECS[i], 32'h8100_0300 + 32'h0102_0204 * i);
      #1;
      checkLanes($sformatf("R1/R2 vec%0d first", i), VECS[i].r1, VECS[i].m1, VECS[i].st);
      if (VECS[i].st) begin
        @(negedge clk);
        checkLanes($sformatf("R2/R5 vec%0d second", i), VECS[i].r2, VECS[i].m2, 1'b0);
      end
    end

    // R9: fetch-valid low with a clashing pair presented
    @(negedge clk);
    fetchValid = 1'b0; loClass = 2'd2; hiClass = 2'd2; isLong = 1'b0; singleIssue = 1'b0;
    #1;
    checkLanes("R9 valid low", 2'd0, 2'd0, 1'b0);

    // R9: reset between the two halves of a split
    @(negedge clk);
    fetchValid = 1'b1; fetchWord = 32'h1234_5678;
    #1;
    checkLanes("R5 split start", 2'd0, 2'd1, 1'b1);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    #1;
    checkLanes("R9 reset clears half", 2'd0, 2'd1, 1'b1);
    @(negedge clk);
    checkLanes("R5 resume high", 2'd0, 2'd2, 1'b0);

    @(negedge clk);
    fetchValid = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule